// File: doc/BRIEF.md
# DRAM Precharge Power-Down Entry Gate

This block sits in the command scheduler of a DDR2-class memory controller and owns the clock-enable pin. It watches every command the scheduler issues, keeps a per-bank open/closed map, and counts clock cycles against three run-time minimums: row precharge time, mode-register set time and the minimum clock-enable low pulse. From these it decides the first cycle in which a power-down request may be honoured, and it drives clock-enable low from the following cycle.

A power-down request may be given as a single-cycle pulse or held as a level. A pulse that arrives while entry is not yet allowed is remembered and served in the first cycle that allows it. A held level also keeps the device in power-down, and clock-enable returns high once the request is released and the minimum low time has passed. Entry after a precharge is allowed in the very next idle cycle, even while the precharge itself is still in progress. Entry after a mode-register load waits for the mode-register set time. A mode-register load issued too soon after a precharge, or while a bank is open, is flagged. Any real command issued while clock-enable is low is also flagged, and it is dropped.

Top module: `pd_entry_gate`

## Requirements
- R1: During and after synchronous active-high reset, `cke` is high, `cmd_err` is low, all banks are closed and all timers count as expired. A request in the first cycle after reset is therefore granted in that same cycle.
- R2: Opcodes on `cmd_op` are NOP=0, ACTIVATE=1, PRECHARGE=2, LOAD MODE=3, and 4 to 7 are other commands with no effect here. ACTIVATE opens bank `cmd_bank`. PRECHARGE with `cmd_a10`=1 closes every bank, and with `cmd_a10`=0 it closes only bank `cmd_bank`. No grant is given while any bank is open.
- R3: A PRECHARGE issued in cycle c allows a grant in cycle c+1, whatever the value of `t_rp`.
- R4: A LOAD MODE in cycle c is legal only if all banks are closed and the last PRECHARGE was at cycle c-`t_rp` or earlier. Otherwise `cmd_err` is high in cycle c+1, and the command has no effect.
- R5: After a legal LOAD MODE in cycle c, `pd_grant` stays low until cycle c+`t_mrd`.
- R6: `pd_grant` is high in a cycle exactly when all of the following hold: `cke` is high, a request is present (`pd_req` high or one pending), no non-NOP command is presented, all banks are closed, and the LOAD MODE wait has run out. `cke` is then low from the next cycle.
- R7: A `pd_req` pulse that cannot be granted at once is held pending. It is granted in the first cycle that meets R6, even if `pd_req` has since dropped.
- R8: Once low, `cke` stays low for at least `t_cke` cycles. It returns high in the first cycle after that minimum in which `pd_req` is low.
- R9: While `cke` is low, a valid non-NOP command makes `cmd_err` high in the next cycle. The command is ignored, so the bank map and the timers do not change.
- R10: A LOAD MODE may select any of the four mode registers through `cmd_bank[1:0]` (0 to 3). Each selection is legal under the conditions of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode |
| cmd_a10 | input | 1 | Address bit 10: all-bank precharge select |
| cmd_bank | input | BANK_W (3) | Bank address; mode register select for LOAD MODE |
| pd_req | input | 1 | Power-down request (pulse or level) |
| t_rp | input | TW (8) | Row precharge minimum in cycles, at least 1 |
| t_mrd | input | TW (8) | Mode-register set minimum in cycles, at least 1 |
| t_cke | input | TW (8) | Minimum clock-enable low time in cycles, at least 1 |
| cke | output | 1 | Clock enable to the DRAM |
| pd_grant | output | 1 | Power-down entry granted this cycle |
| cmd_err | output | 1 | Illegal command seen in the previous cycle |

## Verification
The assertions assume that the three timing inputs are at least 1 and change only while reset is held. Each minimum is measured from the moment the counter is loaded, so a change mid-flight would make them disagree with the counters. The stimulus changes timings only inside reset and draws each value from 1 to 6. It mixes random commands and request toggles with directed sequences that place a LOAD MODE exactly one cycle early and exactly on time, hold a request pending, and issue commands during power-down.

// File: rtl/pd_gate_pkg.sv
package pd_gate_pkg;

  localparam logic [2:0] OP_NOP = 3'd0;
  localparam logic [2:0] OP_ACT = 3'd1;
  localparam logic [2:0] OP_PRE = 3'd2;
  localparam logic [2:0] OP_LMR = 3'd3;

  // A mode-register load is legal only with every bank closed and the
  // precharge timer run out.
  function automatic logic lm_is_legal(input logic banks_idle,
                                       input logic rp_expired);
    return banks_idle && rp_expired;
  endfunction

  // Power-down entry condition for the current cycle.
  function automatic logic entry_allowed(input logic cke_high,
                                         input logic want,
                                         input logic cmd_busy,
                                         input logic banks_idle,
                                         input logic mrd_expired);
    return cke_high && want && !cmd_busy && banks_idle && mrd_expired;
  endfunction

endpackage

// File: rtl/pd_down_counter.sv
module pd_down_counter #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] span,
  output logic          expired
);

  logic [TW-1:0] cnt_q;

  // Loading span-1 makes the counter read zero exactly span cycles after the
  // cycle that loaded it.
  function automatic logic [TW-1:0] reload_value(input logic [TW-1:0] s);
    return (s == '0) ? '0 : s - TW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= reload_value(span);
    else if (cnt_q != '0)   cnt_q <= cnt_q - TW'(1);
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/pd_bank_tracker.sv
module pd_bank_tracker #(
  parameter int BANKS  = 8,
  parameter int BANK_W = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              open_en,
  input  logic              close_en,
  input  logic              close_all,
  input  logic [BANK_W-1:0] bank,
  output logic [BANKS-1:0]  open_mask,
  output logic              all_closed
);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (bank == BANK_W'(b));
    always_ff @(posedge clk) begin
      if (rst)                                open_mask[b] <= 1'b0;
      else if (open_en && hit)                open_mask[b] <= 1'b1;
      else if (close_en && (close_all || hit)) open_mask[b] <= 1'b0;
    end
  end

  assign all_closed = (open_mask == '0);

endmodule

// File: rtl/pd_entry_gate.sv
module pd_entry_gate
  import pd_gate_pkg::*;
#(
  parameter int BANKS  = 8,
  parameter int TW     = 8,
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic              cmd_a10,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              pd_req,
  input  logic [TW-1:0]     t_rp,
  input  logic [TW-1:0]     t_mrd,
  input  logic [TW-1:0]     t_cke,
  output logic              cke,
  output logic              pd_grant,
  output logic              cmd_err
);

  // Named internal events
  logic             cmd_live;
  logic             cmd_in_pd;
  logic             issue;
  logic             is_act;
  logic             is_pre;
  logic             is_lm;
  logic             lm_ok;
  logic             lm_bad;
  logic             want;
  logic             cke_exit;
  logic             all_closed;
  logic             rp_done;
  logic             mrd_done;
  logic             cke_done;
  logic [BANKS-1:0] open_mask;

  logic cke_q;
  logic pend_q;
  logic err_q;

  assign cmd_live  = cmd_valid && (cmd_op != OP_NOP);
  assign cmd_in_pd = cmd_live && !cke_q;
  assign issue     = cmd_live && cke_q;
  assign is_act    = issue && (cmd_op == OP_ACT);
  assign is_pre    = issue && (cmd_op == OP_PRE);
  assign is_lm     = issue && (cmd_op == OP_LMR);
  // Any of the four mode-register selects on cmd_bank[1:0] is accepted.
  assign lm_ok     = is_lm && lm_is_legal(all_closed, rp_done);
  assign lm_bad    = is_lm && !lm_ok;
  assign want      = pd_req || pend_q;
  assign pd_grant  = entry_allowed(cke_q, want, cmd_live, all_closed, mrd_done);
  assign cke_exit  = !cke_q && cke_done && !pd_req;

  pd_bank_tracker #(.BANKS(BANKS), .BANK_W(BANK_W)) u_banks (
    .clk        (clk),
    .rst        (rst),
    .open_en    (is_act),
    .close_en   (is_pre),
    .close_all  (cmd_a10),
    .bank       (cmd_bank),
    .open_mask  (open_mask),
    .all_closed (all_closed)
  );

  pd_down_counter #(.TW(TW)) u_rp (
    .clk (clk), .rst (rst), .load (is_pre), .span (t_rp), .expired (rp_done)
  );

  pd_down_counter #(.TW(TW)) u_mrd (
    .clk (clk), .rst (rst), .load (lm_ok), .span (t_mrd), .expired (mrd_done)
  );

  pd_down_counter #(.TW(TW)) u_cke (
    .clk (clk), .rst (rst), .load (pd_grant), .span (t_cke), .expired (cke_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q  <= 1'b1;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (pd_grant)      cke_q <= 1'b0;
      else if (cke_exit) cke_q <= 1'b1;
      pend_q <= cke_q && want && !pd_grant;
      err_q  <= cmd_in_pd || lm_bad;
    end
  end

  assign cke     = cke_q;
  assign cmd_err = err_q;

endmodule

// File: rtl/pd_entry_gate_chk.sv
module pd_entry_gate_chk #(
  parameter int TW = 8,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cke,
  input logic          pd_grant,
  input logic          cmd_err,
  input logic          cmd_valid,
  input logic [2:0]    cmd_op,
  input logic [TW-1:0] t_mrd,
  input logic [TW-1:0] t_cke,
  input logic          all_closed,
  input logic          lm_ok
);

  logic [CW-1:0] since_lm;
  logic [CW-1:0] low_len;
  logic          past_rst;

  always_ff @(posedge clk) begin
    past_rst <= rst;
    if (rst)                   since_lm <= '1;
    else if (lm_ok)            since_lm <= CW'(1);
    else if (since_lm != '1)   since_lm <= since_lm + CW'(1);
    if (rst || cke)            low_len <= '0;
    else if (low_len != '1)    low_len <= low_len + CW'(1);
  end

  always @(posedge clk) begin
    if (past_rst && !rst)
      AST_RESET_STATE: assert (cke && !cmd_err); // R1
  end

  AST_GRANT_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    pd_grant |-> (cke && all_closed && !(cmd_valid && cmd_op != 3'd0))); // R2

  AST_NO_STRAY_ERR: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> $past(cmd_valid)); // R4

  AST_MRD_RESPECTED: assert property (@(posedge clk) disable iff (rst)
    pd_grant |-> (since_lm >= CW'(t_mrd))); // R5

  AST_GRANT_LOWERS_CKE: assert property (@(posedge clk) disable iff (rst)
    pd_grant |=> !cke); // R6

  AST_CKE_MIN_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> (low_len >= CW'(t_cke))); // R8

  AST_ERR_IN_PD: assert property (@(posedge clk) disable iff (rst)
    (!cke && cmd_valid && cmd_op != 3'd0) |=> cmd_err); // R9

endmodule

bind pd_entry_gate pd_entry_gate_chk #(.TW(TW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cke        (cke),
  .pd_grant   (pd_grant),
  .cmd_err    (cmd_err),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .t_mrd      (t_mrd),
  .t_cke      (t_cke),
  .all_closed (all_closed),
  .lm_ok      (lm_ok)
);

// File: tb/pd_entry_gate_tb.sv
module pd_entry_gate_tb;

  localparam int BANKS = 8;
  localparam int TW    = 8;
  localparam int BW    = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          cmd_valid;
  logic [2:0]    cmd_op;
  logic          cmd_a10;
  logic [BW-1:0] cmd_bank;
  logic          pd_req;
  logic [TW-1:0] t_rp, t_mrd, t_cke;
  logic          cke, pd_grant, cmd_err;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Bench model state (distance counters, not down-counters)
  bit        m_cke, m_pend, m_err;
  bit [7:0]  m_open;
  int        since_pre, since_lm, low_len;
  bit        obs_cke, obs_grant, obs_err;

  always #2 clk = ~clk;

  pd_entry_gate #(.BANKS(BANKS), .TW(TW)) u_dut (
    .clk (clk), .rst (rst), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
    .cmd_a10 (cmd_a10), .cmd_bank (cmd_bank), .pd_req (pd_req),
    .t_rp (t_rp), .t_mrd (t_mrd), .t_cke (t_cke),
    .cke (cke), .pd_grant (pd_grant), .cmd_err (cmd_err)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int sat(input int v);
    return (v > 10000) ? 10000 : v;
  endfunction

  task automatic do_reset(input int rp, input int mrd, input int ck);
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_a10 = 1'b0;
    cmd_bank = '0; pd_req = 1'b0;
    t_rp = TW'(rp); t_mrd = TW'(mrd); t_cke = TW'(ck);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    m_cke = 1; m_pend = 0; m_err = 0; m_open = '0;
    since_pre = 10000; since_lm = 10000; low_len = 0;
  endtask

  // One cycle: drive, compare at the falling edge, advance the model.
  task automatic step(input bit v, input int op, input bit a10,
                      input int bank, input bit req);
    bit live, exp_g, lm_legal, issue;
    cmd_valid = v; cmd_op = 3'(op); cmd_a10 = a10;
    cmd_bank = BW'(bank); pd_req = req;
    @(negedge clk);
    live  = v && (op != 0);
    exp_g = m_cke && (req || m_pend) && !live && (m_open == 0)
            && (since_lm >= int'(t_mrd));
    obs_cke = cke; obs_grant = pd_grant; obs_err = cmd_err;
    check("R8 cke", int'(cke), int'(m_cke));
    check("R2 R3 R5 R6 R7 pd_grant", int'(pd_grant), int'(exp_g));
    check("R4 R9 R10 cmd_err", int'(cmd_err), int'(m_err));
    issue    = live && m_cke;
    lm_legal = (m_open == 0) && (since_pre >= int'(t_rp));
    m_err    = (live && !m_cke) || (issue && op == 3 && !lm_legal);
    since_lm  = (issue && op == 3 && lm_legal) ? 1 : sat(since_lm + 1);
    since_pre = (issue && op == 2) ? 1 : sat(since_pre + 1);
    if (issue && op == 1) m_open[bank] = 1'b1;
    if (issue && op == 2) begin
      if (a10) m_open = '0; else m_open[bank] = 1'b0;
    end
    m_pend = m_cke && (req || m_pend) && !exp_g;
    if (exp_g) begin
      m_cke = 0; low_len = 1;
    end else if (!m_cke) begin
      if (low_len >= int'(t_cke) && !req) m_cke = 1;
      else low_len++;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input bit req);
    step(1'b0, 0, 1'b0, 0, req);
  endtask

  initial begin
    int unsigned seed;
    bit rq;
    seed = $urandom(32'd2024);

    // Directed: reset, precharge-then-entry, tCKE hold
    do_reset(6, 3, 4);
    idle(1'b0);
    check("R1 cke after reset", int'(obs_cke), 1);
    check("R1 err after reset", int'(obs_err), 0);
    step(1'b1, 1, 1'b0, 2, 1'b0);           // ACT bank 2
    step(1'b1, 2, 1'b0, 2, 1'b0);           // PRE bank 2 only
    idle(1'b1);
    check("R3 grant one cycle after PRE", int'(obs_grant), 1);
    idle(1'b0); idle(1'b0); idle(1'b0); idle(1'b0);
    check("R8 cke still low at t_cke", int'(obs_cke), 0);
    idle(1'b0);
    check("R8 cke high after t_cke", int'(obs_cke), 1);

    // Directed: early LOAD MODE, on-time LOAD MODE, pending request
    step(1'b1, 1, 1'b0, 0, 1'b0);           // ACT bank 0
    step(1'b1, 2, 1'b1, 0, 1'b0);           // PRE all
    step(1'b1, 3, 1'b0, 1, 1'b0);           // LM too early
    idle(1'b0);
    check("R4 early LOAD MODE flagged", int'(obs_err), 1);
    for (int i = 0; i < 4; i++) idle(1'b0);
    step(1'b1, 3, 1'b0, 3, 1'b0);           // LM to register 3, on time
    step(1'b0, 0, 1'b0, 0, 1'b1);           // pulse request
    check("R10 LOAD MODE select 3 legal", int'(obs_err), 0);
    check("R5 no grant inside t_mrd", int'(obs_grant), 0);
    idle(1'b0);
    check("R7 still pending", int'(obs_grant), 0);
    idle(1'b0);
    check("R7 pending granted at t_mrd", int'(obs_grant), 1);
    step(1'b1, 1, 1'b0, 5, 1'b0);           // ACT while cke low
    idle(1'b0);
    check("R9 command in power-down flagged", int'(obs_err), 1);
    for (int i = 0; i < 4; i++) idle(1'b1);
    check("R8 held request keeps cke low", int'(obs_cke), 0);
    idle(1'b0); idle(1'b1);
    check("R9 ignored ACT left banks closed", int'(obs_grant), 1);

    // Random segments
    for (int seg = 0; seg < 4; seg++) begin
      do_reset(1 + int'($urandom % 6), 1 + int'($urandom % 6),
               1 + int'($urandom % 6));
      rq = 1'b0;
      for (int n = 0; n < 3000; n++) begin
        int r;
        r = int'($urandom % 100);
        if ($urandom % 5 == 0) rq = !rq;
        if (r < 35)      step(1'b0, int'($urandom % 8), 1'b0, 0, rq);
        else if (r < 50) step(1'b1, 1, 1'b0, int'($urandom % 8), rq);
        else if (r < 72) step(1'b1, 2, ($urandom % 3) != 0, int'($urandom % 8), rq);
        else if (r < 87) step(1'b1, 3, 1'b0, int'($urandom % 4), rq);
        else             step(1'b1, 4 + int'($urandom % 4), 1'b0, int'($urandom % 8), rq);
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule